// File: doc/BRIEF.md
# Best-Effort Wormhole Switch Allocator

This block decides, once per flit period, which best-effort flits cross the crossbar of an input-queued router. Each input offers the flit at the head of its queue: a valid flag, the output port it wants and a flag that marks the last flit of a packet. Each output tracks how many free flit slots its downstream neighbour has, counted in credits. A per-output mask marks outputs that carry a reserved guaranteed-traffic block in the current slot. Reserved outputs are withheld from best-effort traffic.

The allocator performs one round-robin request/grant/accept pass. An output that is free grants one of its requesting inputs. The choice starts at the output's rotating pointer, and the pointer moves past the winner when a packet's first flit is granted. Each input asks for only one output, so the accept step reduces to collecting the single grant into the input's ready signal. After an output forwards a flit that does not close its packet, that output serves only the same input until the closing flit has passed. This is the wormhole lock.

The per-input interface is a valid/ready handshake. A flit moves in the cycle where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source must keep the destination and tail flag unchanged. `in_ready` depends combinationally on the inputs of the same cycle. The per-output `out_valid`/`out_src` pair sets the crossbar for that cycle.

Top module: `be_switch_alloc`

## Requirements
- R1: After reset every output holds `CREDITS` credits, no output is locked and every grant pointer is 0. With no valid input, `in_ready` and `out_valid` are all 0.
- R2: Per cycle an output is granted to at most one input. `out_valid[o]` is high exactly when output o forwards a flit, and `out_src` field o (bits o*PW upward, PW = clog2(NPORT)) holds the index of the forwarding input.
- R3: Per cycle an input is matched to at most one output. `in_ready[i]` is high only when `in_valid[i]` is high and its flit is forwarded.
- R4: Among competing requests for an unlocked output, the grant goes to the first requesting input at or after the output's pointer, in rising index order with wrap-around. Granting an unlocked output moves its pointer to the winner's index plus one, modulo NPORT.
- R5: An output with zero credits grants nothing. Each forwarded flit costs one credit, and each `credit_return[o]` pulse adds one from the next cycle on. A send and a return in the same cycle cancel out.
- R6: While `gt_reserve[o]` is high, output o grants nothing in that cycle, and any wormhole lock on o is kept.
- R7: A forwarded flit with `in_tail` low locks the output to its input. Other inputs are refused until a flit with `in_tail` high passes from that input. A flit with `in_tail` high on an unlocked output leaves the output unlocked.
- R8: The matching is maximal for head-of-line requests. Every output that is unreserved, has credit and has an eligible requester grants one input in that cycle, independently of the other outputs.
- R9: With all inputs persistently sending single-flit packets to one output whose credits are replenished, each input is served within NPORT consecutive flit periods.
- R10: A flit not accepted stays offered with an unchanged destination and tail flag, and it is accepted in the first cycle its output becomes eligible for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flit-period clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Head-of-line flit present, one bit per input |
| in_ready | output | NPORT | Head-of-line flit forwarded this cycle |
| in_dest | input | NPORT*PW | Requested output per input, field i at bits i*PW |
| in_tail | input | NPORT | Head-of-line flit closes its packet |
| gt_reserve | input | NPORT | Output reserved for guaranteed traffic this slot |
| credit_return | input | NPORT | One-credit return pulse per output |
| out_valid | output | NPORT | Output forwards a best-effort flit this cycle |
| out_src | output | NPORT*PW | Input index selected per output, field o at bits o*PW |

## Verification
The bench builds the block with five ports and a credit depth of 3. The small depth means credit exhaustion, and recovery after a single return pulse, are reached after only three flits on one output. Five ports let the pointer wrap-around be seen both in short contention sequences and in a ten-cycle sweep where every input competes for one output, which exposes the fairness bound. The same settings also give room for independent matches across outputs, a reservation that falls in the middle of a locked packet, and a lock released by a tail flit.

// File: rtl/be_alloc_pkg.sv
package be_alloc_pkg;

  // Next pointer position after a winner, wrapping at the port count.
  function automatic int unsigned next_slot(int unsigned idx, int unsigned nport);
    return (idx + 1 >= nport) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/be_rr_pick.sv
module be_rr_pick #(
  parameter int NPORT = 5,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [NPORT-1:0] req,
  input  logic [PW-1:0]    ptr,
  output logic [NPORT-1:0] gnt
);

  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < NPORT; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NPORT;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/be_out_ctrl.sv
module be_out_ctrl
  import be_alloc_pkg::*;
#(
  parameter int NPORT   = 5,
  parameter int CREDITS = 8,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int CW = $clog2(CREDITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] tail,
  input  logic             gt_res,
  input  logic             credit_ret,
  output logic [NPORT-1:0] gnt,
  output logic [PW-1:0]    src
);

  logic [CW-1:0]    cnt;
  logic             locked;
  logic [PW-1:0]    lock_src;
  logic [PW-1:0]    ptr;
  logic [NPORT-1:0] owner_mask;
  logic [NPORT-1:0] cand;
  logic             sent;
  logic             win_tail;

  always_comb begin
    owner_mask = locked ? (NPORT'(1) << lock_src) : '1;
    cand       = (gt_res || cnt == '0) ? '0 : (req & owner_mask);
  end

  be_rr_pick #(.NPORT(NPORT)) u_pick (
    .req (cand),
    .ptr (ptr),
    .gnt (gnt)
  );

  always_comb begin
    src = '0;
    for (int i = 0; i < NPORT; i++)
      if (gnt[i]) src = PW'(i);
    sent     = |gnt;
    win_tail = |(gnt & tail);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= CW'(CREDITS);
      locked   <= 1'b0;
      lock_src <= '0;
      ptr      <= '0;
    end else begin
      if (sent && !credit_ret)      cnt <= cnt - 1'b1;
      else if (!sent && credit_ret) cnt <= cnt + 1'b1;
      if (sent) begin
        locked   <= !win_tail;
        lock_src <= src;
        if (!locked) ptr <= PW'(next_slot(int'(src), NPORT));
      end
    end
  end

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r5_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CREDITS));
  a_r5_return_room: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ret |-> (cnt < CW'(CREDITS) || sent));
  a_r6_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    gt_res |-> !sent);
  a_r7_lock_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && sent) |-> (src == lock_src));
  a_r7_lock_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !sent) |=> (locked && $stable(lock_src)));

endmodule

// File: rtl/be_switch_alloc.sv
module be_switch_alloc #(
  parameter int NPORT   = 5,
  parameter int CREDITS = 8,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    in_valid,
  output logic [NPORT-1:0]    in_ready,
  input  logic [NPORT*PW-1:0] in_dest,
  input  logic [NPORT-1:0]    in_tail,
  input  logic [NPORT-1:0]    gt_reserve,
  input  logic [NPORT-1:0]    credit_return,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*PW-1:0] out_src
);

  // Per output: requests and grants indexed by input.
  logic [NPORT-1:0] req_mat [NPORT];
  logic [NPORT-1:0] gnt_mat [NPORT];

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    always_comb begin
      for (int i = 0; i < NPORT; i++)
        req_mat[o][i] = in_valid[i] && (in_dest[i*PW +: PW] == PW'(o));
    end

    be_out_ctrl #(.NPORT(NPORT), .CREDITS(CREDITS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_mat[o]),
      .tail       (in_tail),
      .gt_res     (gt_reserve[o]),
      .credit_ret (credit_return[o]),
      .gnt        (gnt_mat[o]),
      .src        (out_src[o*PW +: PW])
    );

    assign out_valid[o] = |gnt_mat[o];
  end

  // Accept stage: one head-of-line request per input, so at most one grant.
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [NPORT-1:0] col;
    always_comb begin
      for (int o = 0; o < NPORT; o++) col[o] = gnt_mat[o][i];
    end
    assign in_ready[i] = |col;

    a_r3_single_output: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]);
  end

  a_r2_flit_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_ready) == $countones(out_valid));

endmodule

// File: tb/be_switch_alloc_tb.sv
module be_switch_alloc_tb;

  localparam int N  = 5;
  localparam int PW = 3;
  localparam int CR = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [N*PW-1:0] in_dest = '0;
  logic [N-1:0]    in_tail = '0;
  logic [N-1:0]    gt_reserve = '0;
  logic [N-1:0]    credit_return = '0;
  logic [N-1:0]    out_valid;
  logic [N*PW-1:0] out_src;

  always #2.5 clk = ~clk;

  be_switch_alloc #(.NPORT(N), .CREDITS(CR)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_tail(in_tail), .gt_reserve(gt_reserve),
    .credit_return(credit_return), .out_valid(out_valid), .out_src(out_src)
  );

  typedef struct {
    logic [N-1:0]    rdy;
    logic [N-1:0]    ov;
    logic [N*PW-1:0] src;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  function automatic logic [N*PW-1:0] pk(int a0, int a1, int a2, int a3, int a4);
    return {PW'(a4), PW'(a3), PW'(a2), PW'(a1), PW'(a0)};
  endfunction

  // Driver: apply one flit period of stimulus and queue its expectation.
  task automatic step(input logic [N-1:0] v, input logic [N*PW-1:0] d,
                      input logic [N-1:0] tl, input logic [N-1:0] gt,
                      input logic [N-1:0] cr, input logic [N-1:0] e_rdy,
                      input logic [N-1:0] e_ov, input logic [N*PW-1:0] e_src,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    in_valid = v; in_dest = d; in_tail = tl; gt_reserve = gt; credit_return = cr;
    e.rdy = e_rdy; e.ov = e_ov; e.src = e_src; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic bad;
      e = exp_q.pop_front();
      bad = (in_ready !== e.rdy) || (out_valid !== e.ov);
      for (int o = 0; o < N; o++)
        if (e.ov[o] && out_src[o*PW +: PW] !== e.src[o*PW +: PW]) bad = 1'b1;
      n_cmp++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: rdy=%b ov=%b src=%h expected rdy=%b ov=%b src=%h",
                 e.tag, in_ready, out_valid, out_src, e.rdy, e.ov, e.src);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: idle after reset
    step('0, '0, '0, '0, '0, 5'b00000, 5'b00000, '0, "R1 idle after reset");
    // R4: inputs 1 and 3 contend for output 2, pointer 0 -> input 1
    step(5'b01010, pk(0,2,0,2,0), 5'b11111, '0, '0, 5'b00010, 5'b00100,
         pk(0,0,1,0,0), "R4 first winner from pointer 0");
    // R4: pointer now 2 -> input 3
    step(5'b01010, pk(0,2,0,2,0), 5'b11111, '0, '0, 5'b01000, 5'b00100,
         pk(0,0,3,0,0), "R4 rotation to input 3");
    // R4: pointer now 4, requesters 0 and 3 -> wraps to input 0
    step(5'b01001, pk(2,0,0,2,0), 5'b11111, '0, '0, 5'b00001, 5'b00100,
         pk(0,0,0,0,0), "R4 wrap-around to input 0");
    // R5: output 2 out of credits; R8: output 0 served independently
    step(5'b10010, pk(0,2,0,0,0), 5'b11111, '0, '0, 5'b10000, 5'b00001,
         pk(4,0,0,0,0), "R5 empty credits block, R8 other output granted");
    // R5: credit returned this cycle, not usable until next cycle; R10 held
    step(5'b00010, pk(0,2,0,0,0), 5'b11111, '0, 5'b00100, 5'b00000, 5'b00000,
         '0, "R5 return not yet visible");
    step(5'b00010, pk(0,2,0,0,0), 5'b11111, '0, '0, 5'b00010, 5'b00100,
         pk(0,0,1,0,0), "R10 held flit accepted after credit return");
    // R6: output 1 reserved, output 3 free
    step(5'b00101, pk(1,0,3,0,0), 5'b11111, 5'b00010, '0, 5'b00100, 5'b01000,
         pk(0,0,0,2,0), "R6 reserved output withheld");
    step(5'b00001, pk(1,0,0,0,0), 5'b11111, '0, '0, 5'b00001, 5'b00010,
         pk(0,0,0,0,0), "R6 released reservation serves held flit");
    // R7: wormhole packet from input 2 on output 4
    step(5'b00100, pk(0,0,4,0,0), 5'b00000, '0, '0, 5'b00100, 5'b10000,
         pk(0,0,0,0,2), "R7 head flit locks output");
    step(5'b00001, pk(4,0,0,0,0), 5'b11111, '0, '0, 5'b00000, 5'b00000,
         '0, "R7 other input refused while locked");
    step(5'b00101, pk(4,0,4,0,0), 5'b00001, 5'b10000, '0, 5'b00000, 5'b00000,
         '0, "R6 reservation during locked packet");
    step(5'b00101, pk(4,0,4,0,0), 5'b00101, '0, '0, 5'b00100, 5'b10000,
         pk(0,0,0,0,2), "R7 lock kept across reservation, tail passes");
    step(5'b00001, pk(4,0,0,0,0), 5'b11111, '0, '0, 5'b00001, 5'b10000,
         pk(0,0,0,0,0), "R7 lock released after tail");
    // R3/R8: parallel matches on distinct outputs
    step(5'b00011, pk(0,1,0,0,0), 5'b11111, '0, '0, 5'b00011, 5'b00011,
         pk(0,1,0,0,0), "R3 R8 two inputs on two outputs");
    // R9: all inputs to output 3, credits replenished each cycle
    for (int k = 0; k < 10; k++) begin
      int w;
      w = (3 + k) % N;
      step(5'b11111, pk(3,3,3,3,3), 5'b11111, '0, 5'b01000,
           N'(1) << w, 5'b01000, PW'(w) << (3*PW), "R9 fair rotation");
    end
    step('0, '0, '0, '0, '0, 5'b00000, 5'b00000, '0, "R1 idle at end");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule